// File: doc/BRIEF.md
# Selectable-Policy Down-Counting Timer Interrupt

A 32-bit timer register that counts down by one on every enabled tick. Software loads it through a write port and reads it back through a read port. The block drives an interrupt-pending output and a sticky status bit. The interrupt policy is chosen by a static two-bit mode input, and three policies are supported.

In flag mode, a sticky status bit sets whenever the count passes through its last few values. The bit is cleared only by a dedicated write-one-to-clear strobe. In edge mode, a pending interrupt latches when the count's top (sign) bit changes from 0 to 1, whether by counting or by a write. It is removed when the interrupt controller acknowledges delivery. In level mode, the pending interrupt follows the sign bit of the value last written or counted. An acknowledge has no effect in this mode, and only a write with a clear sign bit removes the interrupt.

In every mode, loading a value below 3 raises the interrupt at once, because that value would run out before software could react. After reset the count holds all ones, and nothing is pending.

Top module: `dec_timer`

## Requirements
- R1: After reset, `count_q` reads 0xFFFFFFFF, and both `irq` and `status` are 0.
- R2: A write loads `wr_data` into `count_q` one cycle later. A tick with no write lowers `count_q` by one, wrapping from 0 to 0xFFFFFFFF. When a write and a tick arrive in the same cycle, the write wins and no decrement takes place.
- R3: In flag mode (`mode_sel` = 2'b00), a tick taken while the count is 2, 1 or 0 sets `status`, and `irq` equals `status`. A tick from a count of 3 or more leaves `status` unchanged.
- R4: In flag mode, `status` stays set through reloads and through `ack`. It is cleared by `stat_clr`, but a setting event in the same cycle wins over the clear.
- R5: In edge mode (`mode_sel` = 2'b01), `irq` latches when bit 31 of the count goes from 0 to 1, by a tick from 0 or by a write. A write with bit 31 set leaves `irq` unchanged if the count already had bit 31 set.
- R6: In edge mode, `ack` clears `irq` one cycle later. A raising event in the same cycle wins over the clear.
- R7: In level mode (`mode_sel` = 2'b10), any write or tick that leaves bit 31 of the count set asserts `irq`. The reset value does not assert it.
- R8: In level mode, `ack` has no effect on `irq`. A write with bit 31 clear and value 3 or more deasserts `irq`.
- R9: In any mode, a write of a value below 3 raises the interrupt one cycle later. In flag mode this sets `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Static policy select: 00 flag, 01 edge, 10 level |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Value to load into the count |
| tick | input | 1 | Decrement enable |
| ack | input | 1 | Interrupt delivered, from the interrupt controller |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| count_q | output | 32 | Current count (read port) |
| irq | output | 1 | Interrupt pending |
| status | output | 1 | Sticky status bit (flag mode) |

## Verification
The hardest situations to reach are the ones where two effects meet in the same cycle. These are a raising event against an acknowledge or a status clear, and a write against a tick. They are reached by driving both strobes together from a single task step, with the count preloaded so that the write itself creates the raising event.

Counting through zero is reached by writing a small value and ticking it down. Each tick is checked in turn, including the 0 to all-ones wrap, which is the sign-bit rise in edge mode.

In level mode, the fact that reset does not assert the interrupt is checked first. Then a single tick from all ones shows the sign-bit rule taking effect.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [1:0] {
        MODE_FLAG  = 2'b00,
        MODE_EDGE  = 2'b01,
        MODE_LEVEL = 2'b10
    } mode_e;

    // events presented by the detector to the interrupt controller
    typedef struct packed {
        logic upd;        // count register changes this cycle
        logic near_tick;  // tick taken from a count below the near limit
        logic msb_rise;   // sign bit goes 0 -> 1
        logic nxt_msb;    // sign bit of the updated count
        logic wr_small;   // write of a value below the near limit
        logic wr_lower;   // write with sign clear and not small
    } dec_evt_t;

    function automatic logic below_limit(input logic [31:0] v, input int unsigned lim);
        return v < lim;
    endfunction

endpackage

// File: rtl/dec_count_reg.sv
module dec_count_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             tick,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] cnt_nxt,
    output logic             upd
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        upd = wr_en | tick;
        if (wr_en)
            cnt_nxt = wr_data;
        else if (tick)
            cnt_nxt = cnt_q - ONE;
        else
            cnt_nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= ALL_ONES;
        else
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/dec_event_detect.sv
module dec_event_detect
    import dec_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int NEAR_LIMIT = 3
) (
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             tick,
    input  logic             upd,
    input  logic [WIDTH-1:0] cnt_q,
    input  logic [WIDTH-1:0] cnt_nxt,
    output dec_evt_t         evt
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] LIMIT = WIDTH'(NEAR_LIMIT);

    logic tick_taken;

    always_comb begin
        tick_taken    = tick & ~wr_en;
        evt.upd       = upd;
        evt.near_tick = tick_taken & (cnt_q < LIMIT);
        evt.msb_rise  = upd & ~cnt_q[MSB] & cnt_nxt[MSB];
        evt.nxt_msb   = cnt_nxt[MSB];
        evt.wr_small  = wr_en & (wr_data < LIMIT);
        evt.wr_lower  = wr_en & ~wr_data[MSB] & ~(wr_data < LIMIT);
    end
endmodule

// File: rtl/dec_irq_ctrl.sv
module dec_irq_ctrl
    import dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_e    mode,
    input  dec_evt_t evt,
    input  logic     ack,
    input  logic     stat_clr,
    output logic     irq,
    output logic     status
);
    logic flag_q, flag_d;
    logic pend_q, pend_d;
    logic flag_set, edge_set, level_set;

    always_comb begin
        flag_set  = evt.near_tick | evt.wr_small;
        edge_set  = evt.msb_rise  | evt.wr_small;
        level_set = evt.wr_small  | (evt.upd & evt.nxt_msb);

        flag_d = flag_q;
        pend_d = pend_q;
        unique case (mode)
            MODE_FLAG: begin
                if (flag_set)      flag_d = 1'b1;
                else if (stat_clr) flag_d = 1'b0;
            end
            MODE_EDGE: begin
                if (edge_set)      pend_d = 1'b1;
                else if (ack)      pend_d = 1'b0;
            end
            MODE_LEVEL: begin
                if (level_set)     pend_d = 1'b1;
                else if (evt.wr_lower) pend_d = 1'b0;
            end
            default: begin
                flag_d = flag_q;
                pend_d = pend_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            pend_q <= pend_d;
        end
    end

    assign status = flag_q;
    assign irq    = (mode == MODE_FLAG) ? flag_q : pend_q;
endmodule

// File: rtl/dec_timer.sv
module dec_timer
    import dec_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int NEAR_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             tick,
    input  logic             ack,
    input  logic             stat_clr,
    output logic [WIDTH-1:0] count_q,
    output logic             irq,
    output logic             status
);
    logic [WIDTH-1:0] cnt_nxt;
    logic             upd;
    dec_evt_t         evt;
    mode_e            mode;

    assign mode = mode_e'(mode_sel);

    dec_count_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
        .cnt_q(count_q), .cnt_nxt(cnt_nxt), .upd(upd)
    );

    dec_event_detect #(.WIDTH(WIDTH), .NEAR_LIMIT(NEAR_LIMIT)) u_evt (
        .wr_en(wr_en), .wr_data(wr_data), .tick(tick), .upd(upd),
        .cnt_q(count_q), .cnt_nxt(cnt_nxt), .evt(evt)
    );

    dec_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .mode(mode), .evt(evt), .ack(ack),
        .stat_clr(stat_clr), .irq(irq), .status(status)
    );
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
    parameter int WIDTH      = 32,
    parameter int NEAR_LIMIT = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_sel,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             tick,
    input logic             ack,
    input logic             stat_clr,
    input logic [WIDTH-1:0] count_q,
    input logic             irq,
    input logic             status
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] LIMIT = WIDTH'(NEAR_LIMIT);

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count_q == {WIDTH{1'b1}} && !irq && !status));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> count_q == $past(wr_data));

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> count_q == $past(count_q) - WIDTH'(1));

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00 && status && !stat_clr) |=> status);

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && ack && !wr_en && !tick) |=> !irq);

    p_level_msb_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10 && (tick || wr_en)) |=> (!count_q[MSB] || irq));

    p_small_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data < LIMIT) |=> irq);
endmodule

bind dec_timer dec_timer_chk #(.WIDTH(WIDTH), .NEAR_LIMIT(NEAR_LIMIT)) u_chk (.*);

// File: tb/dec_timer_tb_top.sv
module dec_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        ack = 1'b0;
    logic        stat_clr = 1'b0;
    logic [31:0] count_q;
    logic        irq;
    logic        status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dec_timer dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .ack(ack), .stat_clr(stat_clr),
        .count_q(count_q), .irq(irq), .status(status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge; outputs are read at the following negedge
    task automatic step(input logic w, input logic [31:0] d, input logic t,
                        input logic a, input logic c);
        wr_en = w; wr_data = d; tick = t; ack = a; stat_clr = c;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; ack = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] m);
        mode_sel = m;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        chk("R1 count", count_q, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 status", {31'd0, status}, 32'd0);
    endtask

    task automatic t_count();
        do_reset(2'b10);
        step(1, 32'd10, 0, 0, 0);
        chk("R2 load", count_q, 32'd10);
        step(0, 0, 1, 0, 0);
        chk("R2 tick", count_q, 32'd9);
        step(1, 32'd100, 1, 0, 0);
        chk("R2 write wins", count_q, 32'd100);
        step(1, 32'd0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R2 wrap", count_q, 32'hFFFF_FFFF);
    endtask

    task automatic t_flag();
        do_reset(2'b00);
        step(1, 32'd4, 0, 0, 0);
        chk("R3 no flag at 4", {31'd0, status}, 32'd0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R3 tick 3->2 no flag", {31'd0, status}, 32'd0);
        step(0, 0, 1, 0, 0);
        chk("R3 tick 2->1 flag", {31'd0, status}, 32'd1);
        chk("R3 irq follows flag", {31'd0, irq}, 32'd1);
        step(0, 0, 0, 0, 1);
        chk("R4 clear strobe", {31'd0, status}, 32'd0);
        step(0, 0, 1, 0, 0);
        chk("R3 tick 1->0 flag", {31'd0, status}, 32'd1);
        step(1, 32'd50, 0, 0, 0);
        chk("R4 survives reload", {31'd0, status}, 32'd1);
        step(0, 0, 0, 1, 0);
        chk("R4 survives ack", {31'd0, status}, 32'd1);
        step(0, 0, 1, 0, 1);
        chk("R4 clear with idle tick", {31'd0, status}, 32'd0);
        step(1, 32'd2, 0, 0, 1);
        chk("R4 set beats clear", {31'd0, status}, 32'd1);
        chk("R9 small write flag", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_edge();
        do_reset(2'b01);
        step(1, 32'd2, 0, 0, 0);
        chk("R9 small write edge", {31'd0, irq}, 32'd1);
        step(0, 0, 0, 1, 0);
        chk("R6 ack clears", {31'd0, irq}, 32'd0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R5 no irq at 0", {31'd0, irq}, 32'd0);
        step(0, 0, 1, 0, 0);
        chk("R5 sign rise by tick", {31'd0, irq}, 32'd1);
        step(0, 0, 0, 1, 0);
        step(1, 32'h8000_0005, 0, 0, 0);
        chk("R5 no rise when sign already set", {31'd0, irq}, 32'd0);
        step(1, 32'd10, 0, 0, 0);
        step(1, 32'h9000_0000, 0, 0, 0);
        chk("R5 sign rise by write", {31'd0, irq}, 32'd1);
        step(0, 0, 0, 1, 0);
        step(1, 32'd5, 0, 0, 0);
        step(1, 32'hA000_0000, 0, 1, 0);
        chk("R6 rise beats ack", {31'd0, irq}, 32'd1);
        chk("R5 status unused", {31'd0, status}, 32'd0);
    endtask

    task automatic t_level();
        do_reset(2'b10);
        chk("R7 reset not asserted", {31'd0, irq}, 32'd0);
        step(0, 0, 1, 0, 0);
        chk("R7 tick keeps sign set", {31'd0, irq}, 32'd1);
        step(1, 32'd4, 0, 0, 0);
        chk("R8 write clears", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0);
        chk("R7 at 0", {31'd0, irq}, 32'd0);
        step(0, 0, 1, 0, 0);
        chk("R7 wrap asserts", {31'd0, irq}, 32'd1);
        step(0, 0, 0, 1, 0);
        chk("R8 ack ignored", {31'd0, irq}, 32'd1);
        step(1, 32'h8000_0000, 0, 0, 0);
        chk("R7 write sign set", {31'd0, irq}, 32'd1);
        step(1, 32'd7, 0, 0, 0);
        chk("R8 write sign clear", {31'd0, irq}, 32'd0);
        step(1, 32'd1, 0, 0, 0);
        chk("R9 small write level", {31'd0, irq}, 32'd1);
        step(0, 0, 1, 0, 0);
        chk("R8 stays until clearing write", {31'd0, irq}, 32'd1);
        step(1, 32'd9, 0, 0, 0);
        chk("R8 final clear", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_count();
        t_flag();
        t_edge();
        t_level();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule